// File: doc/BRIEF.md
# Eight-Region Memory Protection Checker

This block decides, for every memory access, whether the access may proceed under a set of eight programmable protection regions. Each region has a base address, a power-of-two size and an enable bit. For each region, separate permission codes are kept for instruction fetches and for data accesses. The block compares the access address with all regions in parallel and picks the highest-numbered region that matches. It then decodes that region's 4-bit permission code for the current privilege level. It reports read and write rights, the chosen region index and a fault kind: none, background (no region matched) or permission.

No address translation takes place. The physical address output always equals the access address. When protection is switched off, every access is allowed with read and write rights. The decision logic is combinational and feeds one register stage, so each result is available on the clock edge after the access is presented.

Top module: `mpu_region_checker`

## Requirements
- R1: With `prot_en` low, the registered result shows read and write allowed, fault kind 0 (none), `hit` low and region index 0, whatever the region and permission settings are.
- R2: `phys_addr` always equals the access address presented in the previous cycle; no translation is done.
- R3: Bit 0 of a region register enables the region. A region with bit 0 clear never matches.
- R4: Bits [5:1] of a region register hold size code N, and the region spans 2^(N+1) bytes. An address matches when every address bit above bit N equals the same bit of the region register. With N = 31 every address matches.
- R5: When several enabled regions match, the one with the highest index is reported on `hit_region`.
- R6: When no enabled region matches, fault kind is 1 (background), `hit` is low, `hit_region` is 0, and read and write are both denied.
- R7: An instruction fetch (`acc_fetch` high) takes region n's code from `perm_insn[4n+3:4n]`. Any other access takes it from `perm_data[4n+3:4n]`.
- R8: Permission codes give privileged/user rights as follows: 0 none/none; 1 rw/none; 2 rw/r; 3 rw/rw; 5 r/none; 6 r/r. Every other code gives none/none.
- R9: Fault kind 2 (permission) is raised for a matched region when a write lacks write rights, or when a read or fetch lacks read rights. Otherwise the fault kind is 0.
- R10: Holding reset (`rst_n` low) clears all registered outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | Protection checking enable |
| acc_addr | input | 32 | Access address |
| acc_fetch | input | 1 | High for an instruction fetch |
| acc_priv | input | 1 | High for a privileged access |
| acc_write | input | 1 | High for a write access |
| region_cfg | input | 256 | Eight region registers, region n at bits [32n+31:32n] |
| perm_insn | input | 32 | Instruction permission codes, one nibble per region |
| perm_data | input | 32 | Data permission codes, one nibble per region |
| phys_addr | output | 32 | Registered physical address |
| rd_ok | output | 1 | Registered read right |
| wr_ok | output | 1 | Registered write right |
| hit | output | 1 | Registered: an enabled region matched |
| hit_region | output | 3 | Registered index of the chosen region |
| fault_kind | output | 2 | Registered fault kind: 0 none, 1 background, 2 permission |

## Verification
Every result comes from the single output register, so each one is due one rising edge after its access is driven. The bench drives each access on a falling edge and samples all outputs at the next falling edge, which comes just after that register has loaded. Reset values are read while reset is held. The sweeps cover every permission code against each combination of privilege, fetch and write, every size code at its inside and outside boundary addresses, overlapping regions, and the protection-off bypass. The bench computes each expected value directly from the rules above.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    FLT_NONE       = 2'd0,
    FLT_BACKGROUND = 2'd1,
    FLT_PERM       = 2'd2
  } flt_kind_e;

  localparam int unsigned PERM_W = 4;
endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 5
) (
  input  logic [ADDR_W-1:0] region_reg,
  input  logic [ADDR_W-1:0] addr,
  output logic              match
);
  localparam int unsigned SIZE_LSB = 1;

  logic [SIZE_W-1:0] size_code;
  logic [ADDR_W-1:0] span_mask;
  logic              region_on;

  assign size_code = region_reg[SIZE_LSB +: SIZE_W];
  assign region_on = region_reg[0];

  // Mask bit b is set when b <= N, so size code 31 yields all ones with no shift overflow.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign span_mask[b] = (32'(b) <= 32'(size_code));
  end

  assign match = region_on && (((region_reg ^ addr) & ~span_mask) == '0);
endmodule

// File: rtl/mpu_prio_select.sv
module mpu_prio_select #(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [NUM_REGIONS-1:0] match_vec,
  output logic                   any_hit,
  output logic [IDX_W-1:0]       hit_idx
);
  // Ascending scan: a later (higher) index overwrites, so the highest match wins.
  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int unsigned r = 0; r < NUM_REGIONS; r++) begin
      if (match_vec[r]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(r);
      end
    end
  end
endmodule

// File: rtl/mpu_perm_decode.sv
module mpu_perm_decode
  import mpu_pkg::*;
(
  input  logic [PERM_W-1:0] code,
  input  logic              priv,
  output logic              can_rd,
  output logic              can_wr
);
  always_comb begin
    can_rd = 1'b0;
    can_wr = 1'b0;
    unique case (code)
      4'd1: begin can_rd = priv;     can_wr = priv; end
      4'd2: begin can_rd = 1'b1;     can_wr = priv; end
      4'd3: begin can_rd = 1'b1;     can_wr = 1'b1; end
      4'd5: begin can_rd = priv;     can_wr = 1'b0; end
      4'd6: begin can_rd = 1'b1;     can_wr = 1'b0; end
      default: begin can_rd = 1'b0;  can_wr = 1'b0; end
    endcase
  end
endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker
  import mpu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SIZE_W      = 5,
  localparam int unsigned IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned CFG_W      = NUM_REGIONS * ADDR_W,
  localparam int unsigned PERM_ALL_W = NUM_REGIONS * PERM_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prot_en,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic                  acc_fetch,
  input  logic                  acc_priv,
  input  logic                  acc_write,
  input  logic [CFG_W-1:0]      region_cfg,
  input  logic [PERM_ALL_W-1:0] perm_insn,
  input  logic [PERM_ALL_W-1:0] perm_data,
  output logic [ADDR_W-1:0]     phys_addr,
  output logic                  rd_ok,
  output logic                  wr_ok,
  output logic                  hit,
  output logic [IDX_W-1:0]      hit_region,
  output logic [1:0]            fault_kind
);
  logic [NUM_REGIONS-1:0] match_vec;
  logic                   any_hit;
  logic [IDX_W-1:0]       sel_idx;
  logic [PERM_ALL_W-1:0]  perm_src;
  logic [PERM_W-1:0]      sel_code;
  logic                   code_rd, code_wr;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    mpu_region_match #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_match (
      .region_reg (region_cfg[r*ADDR_W +: ADDR_W]),
      .addr       (acc_addr),
      .match      (match_vec[r])
    );
  end

  mpu_prio_select #(.NUM_REGIONS(NUM_REGIONS)) u_select (
    .match_vec (match_vec),
    .any_hit   (any_hit),
    .hit_idx   (sel_idx)
  );

  assign perm_src = acc_fetch ? perm_insn : perm_data;
  assign sel_code = perm_src[sel_idx*PERM_W +: PERM_W];

  mpu_perm_decode u_decode (
    .code   (sel_code),
    .priv   (acc_priv),
    .can_rd (code_rd),
    .can_wr (code_wr)
  );

  // Next-state
  logic                   rd_d, wr_d, hit_d;
  logic [IDX_W-1:0]       idx_d;
  flt_kind_e              flt_d;

  always_comb begin
    rd_d  = 1'b1;
    wr_d  = 1'b1;
    hit_d = 1'b0;
    idx_d = '0;
    flt_d = FLT_NONE;
    if (prot_en) begin
      if (!any_hit) begin
        rd_d  = 1'b0;
        wr_d  = 1'b0;
        flt_d = FLT_BACKGROUND;
      end else begin
        rd_d  = code_rd;
        wr_d  = code_wr;
        hit_d = 1'b1;
        idx_d = sel_idx;
        if (acc_write ? !code_wr : !code_rd) flt_d = FLT_PERM;
      end
    end
  end

  // Output register, always enabled
  logic out_en;
  assign out_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_addr  <= '0;
      rd_ok      <= 1'b0;
      wr_ok      <= 1'b0;
      hit        <= 1'b0;
      hit_region <= '0;
      fault_kind <= FLT_NONE;
    end else if (out_en) begin
      phys_addr  <= acc_addr;
      rd_ok      <= rd_d;
      wr_ok      <= wr_d;
      hit        <= hit_d;
      hit_region <= idx_d;
      fault_kind <= flt_d;
    end
  end

  // Assertions
  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> (rd_ok && wr_ok && !hit && fault_kind == FLT_NONE));

  assert_no_translate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phys_addr == $past(acc_addr)));

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_chk
    assert_disabled_nomatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !region_cfg[r*ADDR_W] |-> !match_vec[r]);
    assert_max_size_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (region_cfg[r*ADDR_W] && region_cfg[r*ADDR_W+1 +: SIZE_W] == {SIZE_W{1'b1}})
        |-> match_vec[r]);
  end

  assert_highest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (match_vec[sel_idx] && (match_vec >> sel_idx) == NUM_REGIONS'(1)));

  assert_background_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_kind == FLT_BACKGROUND) |-> (!rd_ok && !wr_ok && !hit));

  assert_write_needs_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> rd_ok);

  assert_perm_fault_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_kind == FLT_PERM) |-> (hit && !(rd_ok && wr_ok)));
endmodule

// File: tb/mpu_region_checker_tb.sv
module mpu_region_checker_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         prot_en;
  logic [31:0]  acc_addr;
  logic         acc_fetch, acc_priv, acc_write;
  logic [255:0] region_cfg;
  logic [31:0]  perm_insn, perm_data;
  logic [31:0]  phys_addr;
  logic         rd_ok, wr_ok, hit;
  logic [2:0]   hit_region;
  logic [1:0]   fault_kind;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_region_checker u_dut (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .acc_addr(acc_addr),
    .acc_fetch(acc_fetch), .acc_priv(acc_priv), .acc_write(acc_write),
    .region_cfg(region_cfg), .perm_insn(perm_insn), .perm_data(perm_data),
    .phys_addr(phys_addr), .rd_ok(rd_ok), .wr_ok(wr_ok), .hit(hit),
    .hit_region(hit_region), .fault_kind(fault_kind)
  );

  // Expected rights from the code table (R8): returns {rd, wr}
  function automatic logic [1:0] rights(input logic [3:0] code, input logic priv);
    case (code)
      4'd1: return priv ? 2'b11 : 2'b00;
      4'd2: return priv ? 2'b11 : 2'b10;
      4'd3: return 2'b11;
      4'd5: return priv ? 2'b10 : 2'b00;
      4'd6: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic set_region(input int n, input logic [31:0] v);
    region_cfg[n*32 +: 32] = v;
  endtask

  // Drive at falling edge; result registered at next rising edge; sample at following falling edge.
  task automatic access(input logic en, input logic [31:0] a, input logic f,
                        input logic p, input logic w);
    @(negedge clk);
    prot_en = en; acc_addr = a; acc_fetch = f; acc_priv = p; acc_write = w;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [31:0] ea, input logic er,
                            input logic ew, input logic eh, input logic [2:0] ei,
                            input logic [1:0] ef);
    checks++;
    if (phys_addr !== ea || rd_ok !== er || wr_ok !== ew || hit !== eh ||
        hit_region !== ei || fault_kind !== ef) begin
      errors++;
      $display("FAIL %s: got addr=%h rd=%b wr=%b hit=%b idx=%0d flt=%0d, exp addr=%h rd=%b wr=%b hit=%b idx=%0d flt=%0d",
               req, phys_addr, rd_ok, wr_ok, hit, hit_region, fault_kind,
               ea, er, ew, eh, ei, ef);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prot_en = 1'b0; acc_addr = 32'hDEAD_BEEF;
    acc_fetch = 1'b0; acc_priv = 1'b0; acc_write = 1'b0;
    region_cfg = '0; perm_insn = '0; perm_data = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    expect_out("R10", 32'h0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0);
    rst_n = 1'b1;

    // R1 / R2: bypass with protection off, regions configured hostile
    set_region(0, 32'h0000_003F);
    perm_data = '0; perm_insn = '0;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a;
      a = 32'h1357_9BDF * (k + 1);
      access(1'b0, a, k[0], k[1], k[2]);
      expect_out("R1", a, 1'b1, 1'b1, 1'b0, 3'd0, 2'd0);
    end
    set_region(0, 32'h0);

    // R6: no enabled region -> background fault
    access(1'b1, 32'h0000_4000, 1'b0, 1'b1, 1'b0);
    expect_out("R6", 32'h0000_4000, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1);

    // R7 / R8 / R9: region 3 at 0x1000, 4 KB (N=11); full code sweep
    set_region(3, 32'h0000_1000 | (32'd11 << 1) | 32'd1);
    for (int c = 0; c < 16; c++) begin
      perm_data = 32'h3333_3333;
      perm_insn = 32'h3333_3333;
      perm_data[15:12] = 4'(c);
      perm_insn[15:12] = 4'(15 - c);
      for (int m = 0; m < 8; m++) begin
        logic f, p, w;
        logic [3:0] code;
        logic [1:0] rw;
        logic [1:0] ef;
        f = m[0]; p = m[1]; w = m[2];
        code = f ? 4'(15 - c) : 4'(c);
        rw = rights(code, p);
        ef = (w ? !rw[0] : !rw[1]) ? 2'd2 : 2'd0;
        access(1'b1, 32'h0000_1ABC, f, p, w);
        expect_out(f ? "R7 R8 R9 fetch" : "R7 R8 R9 data",
                   32'h0000_1ABC, rw[1], rw[0], 1'b1, 3'd3, ef);
      end
    end
    set_region(3, 32'h0);

    // R4: size sweep on region 0, boundaries inside and outside
    perm_data = 32'h0000_0003;
    for (int n = 0; n < 32; n++) begin
      logic [31:0] rv, mask, ina, outa;
      rv = (32'(n) << 1) | 32'd1;
      mask = (n == 31) ? 32'hFFFF_FFFF : 32'((64'd1 << (n + 1)) - 64'd1);
      ina = (rv & ~mask) | mask;
      set_region(0, rv);
      access(1'b1, ina, 1'b0, 1'b0, 1'b1);
      expect_out("R4 inside", ina, 1'b1, 1'b1, 1'b1, 3'd0, 2'd0);
      if (n < 31) begin
        outa = ina ^ (32'd1 << (n + 1));
        access(1'b1, outa, 1'b0, 1'b0, 1'b1);
        expect_out("R4 outside", outa, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1);
      end
    end
    set_region(0, 32'h0);

    // R5 / R3: overlap of regions 2 and 5, then disable 5
    set_region(2, 32'h0000_0000 | (32'd15 << 1) | 32'd1);
    set_region(5, 32'h0000_0000 | (32'd9 << 1) | 32'd1);
    perm_data = 32'h0060_0300;   // region 2: code 3, region 5: code 6
    access(1'b1, 32'h0000_0100, 1'b0, 1'b1, 1'b1);
    expect_out("R5", 32'h0000_0100, 1'b1, 1'b0, 1'b1, 3'd5, 2'd2);
    access(1'b1, 32'h0000_8000, 1'b0, 1'b1, 1'b1);
    expect_out("R5 lower only", 32'h0000_8000, 1'b1, 1'b1, 1'b1, 3'd2, 2'd0);
    set_region(5, 32'h0000_0000 | (32'd9 << 1));
    access(1'b1, 32'h0000_0100, 1'b0, 1'b1, 1'b1);
    expect_out("R3", 32'h0000_0100, 1'b1, 1'b1, 1'b1, 3'd2, 2'd0);
    set_region(7, 32'h0000_0000 | (32'd31 << 1) | 32'd1);
    perm_data[31:28] = 4'd5;
    access(1'b1, 32'hFFFF_FFF0, 1'b0, 1'b0, 1'b0);
    expect_out("R5 top", 32'hFFFF_FFF0, 1'b0, 1'b0, 1'b1, 3'd7, 2'd2);

    // R10: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_out("R10 async", 32'h0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule